// File: doc/BRIEF.md
# Sign-Steered Chip Cross-Correlation Accumulator

This block builds, symbol by symbol, the cross-correlation between a vector of antipodal data bits and the complex chip samples received over the same symbol. Each bit is one row of a matrix. Each chip position is one column. Every matrix entry holds a 16-bit in-phase sum and a 16-bit quadrature sum. Because a bit is either +1 or -1, no multiplier is used. The bit's sign chooses whether the block adds the sign-extended 8-bit sample to the stored sum or subtracts it.

A symbol starts with a start strobe on its first chip. That strobe also captures the bit vector and a window-clear flag. After the last chip is accepted, the block sweeps the whole matrix in row-major order, with the chip index innermost. It handles one entry per clock through a three-stage read-modify-write pipeline around an on-chip RAM. A symbol whose clear flag is set writes plus or minus the sample directly, so a new correlation window begins without a separate clearing pass. Results of the pipeline that have not yet reached the RAM are forwarded, both to later updates and to the read port. Reads are served while the block is idle.

Top module: `xcorr_acc`

## Requirements
- R1: After reset, `busy` and `rdValid` are low.
- R2: For a symbol started with `clearWin` high, entry (row r, chip c) becomes +s when `bitVec[r]` is 1 and -s when it is 0. Here s is the chip's 8-bit two's-complement sample, sign-extended, handled separately for I and Q.
- R3: For a symbol started with `clearWin` low, entry (r, c) becomes its previous value plus s when `bitVec[r]` is 1, or minus s when it is 0.
- R4: Chips are counted only in cycles with `chipValid` high, so gaps are allowed. Once the CHIPS-th chip is accepted, `busy` stays high for exactly ROWS*CHIPS cycles (one per entry) and then falls.
- R5: While `busy` is high, `symStart`, `chipValid`, `chipI`, `chipQ`, `bitVec` and `clearWin` have no effect on any entry.
- R6: A read request (`rdEn` with `rdRow`, `rdChip`) is accepted only in a cycle where `busy` is low. It yields a one-cycle `rdValid` pulse two clock edges later, carrying the entry's I on `rdI` and Q on `rdQ`. A request made while `busy` is high produces no pulse.
- R7: A read made in the first idle cycle after a sweep, and a symbol that begins right after the previous sweep, both see the latest values of entries whose RAM write is still in flight.
- R8: The sums wrap modulo 2^16 in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| symStart | input | 1 | Marks the first chip of a symbol; honoured when idle |
| clearWin | input | 1 | Sampled with `symStart`: start a new correlation window |
| bitVec | input | ROWS | Bit vector, sampled with `symStart`; 1 means +1, 0 means -1 |
| chipValid | input | 1 | A chip sample is present this cycle |
| chipI | input | SAMP_W | In-phase chip sample, two's complement |
| chipQ | input | SAMP_W | Quadrature chip sample, two's complement |
| busy | output | 1 | Loading chips or sweeping the matrix |
| rdEn | input | 1 | Read request, honoured when idle |
| rdRow | input | log2(ROWS) | Row of the entry to read |
| rdChip | input | log2(CHIPS) | Chip column of the entry to read |
| rdValid | output | 1 | Read data valid |
| rdI | output | ACC_W | In-phase sum of the read entry |
| rdQ | output | ACC_W | Quadrature sum of the read entry |

## Verification
A wrong sign decision, a lost clear flag, or an address mix-up in the row-major walk corrupts only the entries it touches. It shows up at the read port as soon as that entry is read after the sweep, so the bench reads back the full matrix after each symbol. A missing forward is visible only when a read or an update reaches an entry in the two cycles before its write commits. The bench therefore reads the last and second-to-last entries in the first idle cycle, and runs back-to-back symbols on a one-entry instance, where the stale value shows up at the next read. A miscounted sweep shows up directly as a `busy` high time different from ROWS*CHIPS.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SWEEP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take bit vector and clear flag
    logic load;      // write one chip into the buffer
    logic issueUpd;  // start a read-modify-write on the addressed entry
    logic issueRd;   // start an external read of the addressed entry
  } ctlStrobe_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int CHIPS = 32,
  localparam int RW    = idxWidth(ROWS),
  localparam int CW    = idxWidth(CHIPS),
  localparam int DEPTH = ROWS * CHIPS,
  localparam int KW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symStart,
  input  logic             chipValid,
  input  logic             rdEn,
  input  logic [RW-1:0]    rdRow,
  input  logic [CW-1:0]    rdChip,
  output ctlStrobe_t       ctl,
  output logic [CW-1:0]    loadIdx,
  output logic [RW-1:0]    row,
  output logic [CW-1:0]    chip,
  output logic             busy
);

  ctlState_t state, stateNxt;
  logic [CW-1:0] loadCnt;
  logic [RW-1:0] rowCnt;
  logic [CW-1:0] chipCnt;
  logic lastChip, lastRow;

  assign lastChip = (chipCnt == CW'(CHIPS - 1));
  assign lastRow  = (rowCnt == RW'(ROWS - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    loadIdx  = loadCnt;
    row      = rowCnt;
    chip     = chipCnt;
    unique case (state)
      ST_IDLE: begin
        if (chipValid && symStart) begin
          ctl.capture = 1'b1;
          ctl.load    = 1'b1;
          loadIdx     = '0;
          stateNxt    = (CHIPS == 1) ? ST_SWEEP : ST_LOAD;
        end else if (rdEn) begin
          ctl.issueRd = 1'b1;
          row         = rdRow;
          chip        = rdChip;
        end
      end
      ST_LOAD: begin
        if (chipValid) begin
          ctl.load = 1'b1;
          if (loadCnt == CW'(CHIPS - 1)) stateNxt = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        ctl.issueUpd = 1'b1;
        if (lastRow && lastChip) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadCnt <= '0;
      rowCnt  <= '0;
      chipCnt <= '0;
    end else begin
      state <= stateNxt;
      if (ctl.load) loadCnt <= (state == ST_IDLE) ? CW'(1) : loadCnt + 1'b1;
      if (ctl.issueUpd) begin
        if (lastChip) begin
          chipCnt <= '0;
          rowCnt  <= lastRow ? '0 : rowCnt + 1'b1;
        end else begin
          chipCnt <= chipCnt + 1'b1;
        end
      end
    end
  end

  // checker: number of entry updates in one busy period
  logic [KW-1:0] chkCnt;
  always_ff @(posedge clk) begin
    if (!rstN) chkCnt <= '0;
    else if (state == ST_IDLE) chkCnt <= '0;
    else if (ctl.issueUpd) chkCnt <= chkCnt + 1'b1;
  end

  p_sweep_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (chkCnt == KW'(DEPTH)));

endmodule

// File: rtl/xcorr_datapath.sv
module xcorr_datapath
  import xcorr_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int CHIPS  = 32,
  parameter int SAMP_W = 8,
  parameter int ACC_W  = 16,
  localparam int RW    = idxWidth(ROWS),
  localparam int CW    = idxWidth(CHIPS),
  localparam int DEPTH = ROWS * CHIPS,
  localparam int AW    = idxWidth(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [CW-1:0]     loadIdx,
  input  logic [RW-1:0]     row,
  input  logic [CW-1:0]     chip,
  input  logic [ROWS-1:0]   bitVec,
  input  logic              clearWin,
  input  logic [SAMP_W-1:0] chipI,
  input  logic [SAMP_W-1:0] chipQ,
  output logic              rdValid,
  output logic [ACC_W-1:0]  rdI,
  output logic [ACC_W-1:0]  rdQ
);

  typedef logic [1:0][ACC_W-1:0]  accPair_t;   // [0] = I, [1] = Q
  typedef logic [1:0][SAMP_W-1:0] sampPair_t;

  logic [ROWS-1:0] bitReg;
  logic            clrReg;
  sampPair_t       chipBuf [CHIPS];
  accPair_t        mem [DEPTH];
  accPair_t        ramQ;

  logic [AW-1:0] addr;
  logic          issue;
  assign addr  = AW'(row) * AW'(CHIPS) + AW'(chip);
  assign issue = ctl.issueUpd | ctl.issueRd;

  // symbol capture and chip buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitReg <= '0;
      clrReg <= 1'b0;
    end else if (ctl.capture) begin
      bitReg <= bitVec;
      clrReg <= clearWin;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.load) chipBuf[loadIdx] <= {chipQ, chipI};
  end

  // stage 1: RAM read in flight
  logic          s1Valid, s1Read, s1Clr, s1Neg;
  logic [AW-1:0] s1Addr;
  sampPair_t     s1Samp;
  // stage 2: result waiting for write / read output
  logic          s2Valid, s2Write;
  logic [AW-1:0] s2Addr;
  accPair_t      s2Data;
  // stage 3: last committed write
  logic          s3Valid;
  logic [AW-1:0] s3Addr;
  accPair_t      s3Data;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Read  <= 1'b0;
      s1Clr   <= 1'b0;
    end else begin
      s1Valid <= issue;
      s1Read  <= ctl.issueRd;
      s1Clr   <= ctl.issueUpd & clrReg;
    end
    s1Neg  <= ~bitReg[row];
    s1Addr <= addr;
    s1Samp <= chipBuf[chip];
  end

  // forwarding of writes not yet visible in ramQ
  accPair_t base, nxt;
  always_comb begin
    if (s2Valid && s2Write && (s2Addr == s1Addr)) base = s2Data;
    else if (s3Valid && (s3Addr == s1Addr))       base = s3Data;
    else                                          base = ramQ;
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [ACC_W-1:0] sampExt, seed;
    assign sampExt = {{(ACC_W - SAMP_W){s1Samp[ln][SAMP_W-1]}}, s1Samp[ln]};
    assign seed    = s1Clr ? '0 : base[ln];
    assign nxt[ln] = s1Neg ? (seed - sampExt) : (seed + sampExt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s3Valid <= 1'b0;
    end else begin
      s2Valid <= s1Valid;
      s2Write <= s1Valid & ~s1Read;
      s3Valid <= s2Valid & s2Write;
    end
    s2Addr <= s1Addr;
    s2Data <= s1Read ? base : nxt;
    s3Addr <= s2Addr;
    s3Data <= s2Data;
  end

  // accumulator RAM: one write port, one synchronous read port
  always_ff @(posedge clk) begin
    if (s2Valid && s2Write) mem[s2Addr] <= s2Data;
    if (issue) ramQ <= mem[addr];
  end

  assign rdValid = s2Valid & ~s2Write;
  assign rdI     = s2Data[0];
  assign rdQ     = s2Data[1];

  p_ram_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (s2Valid && s2Write) |=> (mem[$past(s2Addr)] == $past(s2Data)));

endmodule

// File: rtl/xcorr_acc.sv
module xcorr_acc
  import xcorr_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int CHIPS  = 32,
  parameter int SAMP_W = 8,
  parameter int ACC_W  = 16,
  localparam int RW    = idxWidth(ROWS),
  localparam int CW    = idxWidth(CHIPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symStart,
  input  logic              clearWin,
  input  logic [ROWS-1:0]   bitVec,
  input  logic              chipValid,
  input  logic [SAMP_W-1:0] chipI,
  input  logic [SAMP_W-1:0] chipQ,
  output logic              busy,
  input  logic              rdEn,
  input  logic [RW-1:0]     rdRow,
  input  logic [CW-1:0]     rdChip,
  output logic              rdValid,
  output logic [ACC_W-1:0]  rdI,
  output logic [ACC_W-1:0]  rdQ
);

  ctlStrobe_t    ctl;
  logic [CW-1:0] loadIdx;
  logic [RW-1:0] row;
  logic [CW-1:0] chip;

  xcorr_ctrl #(.ROWS(ROWS), .CHIPS(CHIPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .symStart(symStart), .chipValid(chipValid),
    .rdEn(rdEn), .rdRow(rdRow), .rdChip(rdChip), .ctl(ctl),
    .loadIdx(loadIdx), .row(row), .chip(chip), .busy(busy)
  );

  xcorr_datapath #(.ROWS(ROWS), .CHIPS(CHIPS), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadIdx(loadIdx), .row(row),
    .chip(chip), .bitVec(bitVec), .clearWin(clearWin), .chipI(chipI),
    .chipQ(chipQ), .rdValid(rdValid), .rdI(rdI), .rdQ(rdQ)
  );

  p_rd_origin_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdEn, 2) && !$past(busy, 2)));

  p_bits_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(u_dp.bitReg));

endmodule

// File: tb/xcorr_acc_tb.sv
module xcorr_acc_tb;
  localparam int ROWS = 8, CHIPS = 32, RW = 3, CW = 5, DEPTH = ROWS * CHIPS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic symStart = 0, clearWin = 0, chipValid = 0, rdEn = 0;
  logic [ROWS-1:0] bitVec = '0;
  logic [7:0] chipI = '0, chipQ = '0;
  logic [RW-1:0] rdRow = '0;
  logic [CW-1:0] rdChip = '0;
  logic busy, rdValid;
  logic [15:0] rdI, rdQ;

  logic symStartM = 0, clearWinM = 0, chipValidM = 0, rdEnM = 0;
  logic [0:0] bitVecM = '0, rdRowM = '0, rdChipM = '0;
  logic [7:0] chipIM = '0, chipQM = '0;
  logic busyM, rdValidM;
  logic [15:0] rdIM, rdQM;

  xcorr_acc #(.ROWS(ROWS), .CHIPS(CHIPS)) u_dut (
    .clk(clk), .rstN(rstN), .symStart(symStart), .clearWin(clearWin),
    .bitVec(bitVec), .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ),
    .busy(busy), .rdEn(rdEn), .rdRow(rdRow), .rdChip(rdChip),
    .rdValid(rdValid), .rdI(rdI), .rdQ(rdQ)
  );

  xcorr_acc #(.ROWS(1), .CHIPS(1)) u_dutMin (
    .clk(clk), .rstN(rstN), .symStart(symStartM), .clearWin(clearWinM),
    .bitVec(bitVecM), .chipValid(chipValidM), .chipI(chipIM), .chipQ(chipQM),
    .busy(busyM), .rdEn(rdEnM), .rdRow(rdRowM), .rdChip(rdChipM),
    .rdValid(rdValidM), .rdI(rdIM), .rdQ(rdQM)
  );

  int nChecks = 0, nFails = 0;
  int modelI [ROWS][CHIPS];
  int modelQ [ROWS][CHIPS];
  logic [7:0] pI [CHIPS];
  logic [7:0] pQ [CHIPS];
  int mI = 0, mQ = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sx8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic int sx16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic loadPattern(input int seed);
    for (int c = 0; c < CHIPS; c++) begin
      pI[c] = 8'((c * 29 + seed * 71) % 256);
      pQ[c] = 8'((c * 53 + seed * 17 + 13) % 256);
    end
  endtask

  // starts and ends at a falling edge; returns in the first idle cycle
  task automatic sendSymbol(input bit clr, input logic [ROWS-1:0] bits,
                            input int gap, input bit noise, input string req);
    int cnt;
    for (int c = 0; c < CHIPS; c++) begin
      symStart = (c == 0); clearWin = clr; bitVec = bits;
      chipValid = 1'b1; chipI = pI[c]; chipQ = pQ[c];
      @(negedge clk);
      if (gap > 0 && (c % gap) == gap - 1 && c != CHIPS - 1) begin
        chipValid = 1'b0; symStart = 1'b0; chipI = 8'h3c; chipQ = 8'hc3;
        @(negedge clk);
      end
    end
    symStart = 0; chipValid = 0; clearWin = 0;
    cnt = 0;
    while (busy && cnt < DEPTH + 10) begin
      if (noise) begin
        symStart = 1; chipValid = 1; chipI = 8'h55; chipQ = 8'haa;
        bitVec = ~bits; clearWin = 1; rdEn = 1;
        check(rdValid == 1'b0, "R6", "rdValid during sweep", int'(rdValid), 0);
      end
      cnt++;
      @(negedge clk);
    end
    symStart = 0; chipValid = 0; clearWin = 0; rdEn = 0;
    check(cnt == DEPTH, "R4", {req, " busy cycles after last chip"}, cnt, DEPTH);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < CHIPS; c++) begin
        int bI = clr ? 0 : modelI[r][c];
        int bQ = clr ? 0 : modelQ[r][c];
        modelI[r][c] = bits[r] ? bI + sx8(pI[c]) : bI - sx8(pI[c]);
        modelQ[r][c] = bits[r] ? bQ + sx8(pQ[c]) : bQ - sx8(pQ[c]);
      end
  endtask

  task automatic readEntry(input int r, input int c, input string req);
    rdEn = 1; rdRow = RW'(r); rdChip = CW'(c);
    @(negedge clk);
    rdEn = 0;
    @(negedge clk);
    check(rdValid == 1'b1, req, $sformatf("rdValid entry %0d,%0d", r, c), int'(rdValid), 1);
    check(rdI == 16'(modelI[r][c]), req, $sformatf("I entry %0d,%0d", r, c),
          sx16(rdI), sx16(16'(modelI[r][c])));
    check(rdQ == 16'(modelQ[r][c]), req, $sformatf("Q entry %0d,%0d", r, c),
          sx16(rdQ), sx16(16'(modelQ[r][c])));
  endtask

  task automatic readAll(input string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < CHIPS; c++) readEntry(r, c, req);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(rdValid == 1'b0, "R1", "rdValid after reset", int'(rdValid), 0);
    check(busyM == 1'b0, "R1", "busy (1x1) after reset", int'(busyM), 0);
  endtask

  task automatic testReadTiming();
    rdEn = 1; rdRow = RW'(2); rdChip = CW'(5);
    @(negedge clk);
    rdEn = 0;
    check(rdValid == 1'b0, "R6", "rdValid one edge after request", int'(rdValid), 0);
    @(negedge clk);
    check(rdValid == 1'b1, "R6", "rdValid two edges after request", int'(rdValid), 1);
    check(rdI == 16'(modelI[2][5]), "R6", "read I value", sx16(rdI), modelI[2][5]);
    @(negedge clk);
    check(rdValid == 1'b0, "R6", "rdValid pulse width", int'(rdValid), 0);
  endtask

  task automatic sendMin(input bit clr, input bit b, input int vI, input int vQ);
    symStartM = 1; chipValidM = 1; clearWinM = clr; bitVecM = b;
    chipIM = 8'(vI); chipQM = 8'(vQ);
    @(negedge clk);
    symStartM = 0; chipValidM = 0; clearWinM = 0;
    while (busyM) @(negedge clk);
    mI = (clr ? 0 : mI) + (b ? vI : -vI);
    mQ = (clr ? 0 : mQ) + (b ? vQ : -vQ);
  endtask

  task automatic readMin(input string req);
    rdEnM = 1;
    @(negedge clk);
    rdEnM = 0;
    @(negedge clk);
    check(rdValidM == 1'b1, req, "rdValid (1x1)", int'(rdValidM), 1);
    check(rdIM == 16'(mI), req, "I (1x1)", sx16(rdIM), sx16(16'(mI)));
    check(rdQM == 16'(mQ), req, "Q (1x1)", sx16(rdQM), sx16(16'(mQ)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);

    // R2: new window, sign per row, full-range samples
    loadPattern(1);
    sendSymbol(1'b1, 8'b1010_0110, 0, 1'b0, "R2");
    readAll("R2");

    // R3: accumulate, chip gaps during load (R4)
    loadPattern(2);
    sendSymbol(1'b0, 8'b0111_0001, 3, 1'b0, "R3");
    readAll("R3");

    // R5: inputs toggled during the sweep have no effect
    loadPattern(3);
    sendSymbol(1'b0, 8'b1100_1011, 0, 1'b1, "R5");
    @(negedge clk);
    check(rdValid == 1'b0, "R6", "no pulse from request made while busy", int'(rdValid), 0);
    @(negedge clk);
    check(rdValid == 1'b0, "R6", "no late pulse from busy request", int'(rdValid), 0);
    readAll("R5");

    testReadTiming();

    // R7: reads in the first idle cycle hit in-flight writes
    loadPattern(7);
    sendSymbol(1'b0, 8'b1111_0000, 0, 1'b0, "R7");
    readEntry(ROWS - 1, CHIPS - 1, "R7");
    loadPattern(8);
    sendSymbol(1'b0, 8'b0101_1010, 0, 1'b0, "R7");
    readEntry(ROWS - 1, CHIPS - 2, "R7");

    // R2: a later window restarts from the sample itself
    loadPattern(4);
    sendSymbol(1'b1, 8'b0000_1111, 2, 1'b0, "R2");
    readAll("R2");

    // R7: back-to-back symbols on a single entry
    sendMin(1'b1, 1'b1, 10, -3);
    sendMin(1'b0, 1'b0, 4, 7);
    sendMin(1'b0, 1'b1, -20, 1);
    readMin("R7");
    sendMin(1'b1, 1'b0, 5, -128);
    readMin("R2");

    // R8: wrap modulo 2^16
    sendMin(1'b1, 1'b1, 127, -128);
    for (int k = 0; k < 299; k++) sendMin(1'b0, 1'b1, 127, -128);
    readMin("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule